// File: doc/BRIEF.md
# Serial Even-Parity Frame Checker

This block checks fixed-length serial frames for even parity. Bits arrive one per accepted transfer on a valid/ready input. The checker counts the position of each bit inside the frame and keeps one running-parity bit as it goes. When the final bit of the frame is consumed, it pulses a frame-done flag in that same cycle. In that cycle it also raises an error flag if the frame holds an odd number of ones.

After the final bit the checker parks and drops its ready signal, so an upstream source sees back-pressure rather than losing data. A bit offered while ready is low is not consumed. The source must keep valid and the bit steady until it sees ready high. Only a re-arm pulse brings the checker back to the first position with even parity. That pulse may arrive at any time, including mid-frame. A re-arm pulse takes priority over a transfer offered in the same cycle: ready is low during the pulse, so that bit is not consumed.

Top module: `even_parity_frame_checker`

## Requirements
- R1: After reset, bit_ready_o is 1 and busy_o, frame_done_o and parity_err_o are all 0.
- R2: A bit is consumed only in a cycle where bit_valid_i and bit_ready_o are both 1. Each consumed bit advances the frame position by one. busy_o is 1 from the cycle after the first consumed bit until the frame ends.
- R3: The running parity flips on each consumed 1 and is unchanged by each consumed 0. Cycles with bit_valid_i low advance neither the position nor the parity.
- R4: frame_done_o is 1 for exactly the one cycle in which the FRAME_BITS-th consumed bit (8 by default) is transferred. It is 0 in every other cycle.
- R5: parity_err_o is 1 in that cycle if and only if the count of ones among the frame's bits is odd. It is never 1 while frame_done_o is 0.
- R6: From the cycle after the final bit until a re-arm pulse, bit_ready_o and busy_o are 0. Offered bits are not consumed and produce no frame_done_o.
- R7: A cycle with sync_i high returns the checker to position 0 with even parity, discarding any partial frame. In the following cycle bit_ready_o is 1 (if sync_i is low) and busy_o is 0.
- R8: While sync_i is high, bit_ready_o is 0. A bit offered in that cycle is not consumed, and frame_done_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Re-arm pulse: restart at position 0, even parity |
| bit_valid_i | input | 1 | Serial bit is offered |
| bit_i | input | 1 | Serial data bit |
| bit_ready_o | output | 1 | Checker can consume a bit this cycle |
| frame_done_o | output | 1 | Final bit of the frame consumed this cycle |
| parity_err_o | output | 1 | Frame completed this cycle with odd parity |
| busy_o | output | 1 | A frame is partly received |

## Verification
The bench sweeps all 256 eight-bit frames, with idle gaps placed at varying positions. If a design miscounted idle cycles as bits, the done pulse would come too early. If parity were tracked wrongly, the error flag would disagree with the arithmetic ones count on some frames. After each frame it offers bits while the checker is parked. A design without back-pressure would consume those bits and start a phantom frame. It also fires a re-arm pulse mid-frame together with a valid bit. If the design let the bit through or kept the stale parity, the next frame would finish a cycle early or report the wrong verdict.

// File: rtl/epc_pkg.sv
package epc_pkg;
  typedef enum logic {
    PH_COLLECT = 1'b0,
    PH_PARKED  = 1'b1
  } phase_e;
endpackage

// File: rtl/epc_position_ctr.sv
module epc_position_ctr #(
  parameter int FRAME_BITS = 8,
  localparam int POS_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rearm,
  input  logic             take,
  output logic [POS_W-1:0] pos_q,
  output logic             at_last,
  output epc_pkg::phase_e  phase_q
);
  import epc_pkg::*;

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  assign at_last = (pos_q == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      phase_q <= PH_COLLECT;
    end else if (rearm) begin
      pos_q   <= '0;
      phase_q <= PH_COLLECT;
    end else if (take) begin
      if (at_last) begin
        pos_q   <= '0;
        phase_q <= PH_PARKED;
      end else begin
        pos_q   <= pos_q + POS_W'(1);
      end
    end
  end
endmodule

// File: rtl/epc_parity_trk.sv
module epc_parity_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic take,
  input  logic closing,
  input  logic bit_in,
  output logic par_next
);
  logic par_q;

  assign par_next = par_q ^ bit_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                par_q <= 1'b0;
    else if (rearm)            par_q <= 1'b0;
    else if (take && closing)  par_q <= 1'b0;
    else if (take)             par_q <= par_next;
  end
endmodule

// File: rtl/epc_verdict.sv
module epc_verdict (
  input  logic take,
  input  logic closing,
  input  logic par_next,
  output logic done,
  output logic err
);
  always_comb begin
    done = take && closing;
    err  = done && par_next;
  end
endmodule

// File: rtl/even_parity_frame_checker.sv
module even_parity_frame_checker #(
  parameter int FRAME_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic bit_valid_i,
  input  logic bit_i,
  output logic bit_ready_o,
  output logic frame_done_o,
  output logic parity_err_o,
  output logic busy_o
);
  import epc_pkg::*;

  localparam int POS_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;

  logic [POS_W-1:0] pos;
  logic             at_last;
  phase_e           phase;
  logic             take;
  logic             par_next;

  assign bit_ready_o = (phase == PH_COLLECT) && !sync_i;
  assign take        = bit_valid_i && bit_ready_o;
  assign busy_o      = (phase == PH_COLLECT) && (pos != '0);

  epc_position_ctr #(.FRAME_BITS(FRAME_BITS)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .rearm   (sync_i),
    .take    (take),
    .pos_q   (pos),
    .at_last (at_last),
    .phase_q (phase)
  );

  epc_parity_trk u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .rearm    (sync_i),
    .take     (take),
    .closing  (at_last),
    .bit_in   (bit_i),
    .par_next (par_next)
  );

  epc_verdict u_verdict (
    .take     (take),
    .closing  (at_last),
    .par_next (par_next),
    .done     (frame_done_o),
    .err      (parity_err_o)
  );
endmodule

// File: rtl/epc_checker.sv
module epc_checker #(
  parameter int FRAME_BITS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic sync_i,
  input logic bit_valid_i,
  input logic bit_ready_o,
  input logic frame_done_o,
  input logic parity_err_o,
  input logic busy_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          seen_q <= '0;
    else if (sync_i)                     seen_q <= '0;
    else if (bit_valid_i && bit_ready_o) begin
      if (frame_done_o) seen_q <= '0;
      else              seen_q <= seen_q + CNT_W'(1);
    end
  end

  // R4
  done_on_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (bit_valid_i && bit_ready_o));

  // R4
  done_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (seen_q == CNT_W'(FRAME_BITS - 1)));

  // R5
  err_within_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err_o |-> frame_done_o);

  // R6
  park_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> (!bit_ready_o && !busy_o));

  // R6
  park_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_ready_o && !sync_i) |=> !bit_ready_o);

  // R7
  sync_rearms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (!busy_o && (bit_ready_o || sync_i)));

  // R8
  sync_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |-> (!bit_ready_o && !frame_done_o));
endmodule

bind even_parity_frame_checker epc_checker #(.FRAME_BITS(FRAME_BITS)) u_epc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .sync_i       (sync_i),
  .bit_valid_i  (bit_valid_i),
  .bit_ready_o  (bit_ready_o),
  .frame_done_o (frame_done_o),
  .parity_err_o (parity_err_o),
  .busy_o       (busy_o)
);

// File: tb/even_parity_frame_checker_tb.sv
module even_parity_frame_checker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0;
  logic bit_valid_i = 1'b0;
  logic bit_i = 1'b0;
  logic bit_ready_o, frame_done_o, parity_err_o, busy_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  even_parity_frame_checker #(.FRAME_BITS(8)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_i       (sync_i),
    .bit_valid_i  (bit_valid_i),
    .bit_i        (bit_i),
    .bit_ready_o  (bit_ready_o),
    .frame_done_o (frame_done_o),
    .parity_err_o (parity_err_o),
    .busy_o       (busy_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge, sample 2 ns before the rising edge.
  task automatic cyc(input logic v, input logic b, input logic s,
                     input logic e_rdy, input logic e_done, input logic e_err,
                     input logic e_busy, input string req);
    @(negedge clk);
    bit_valid_i = v; bit_i = b; sync_i = s;
    #2;
    check(req, "bit_ready_o",  bit_ready_o,  e_rdy);
    check(req, "frame_done_o", frame_done_o, e_done);
    check(req, "parity_err_o", parity_err_o, e_err);
    check(req, "busy_o",       busy_o,       e_busy);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    check("R1", "bit_ready_o",  bit_ready_o,  1'b1);
    check("R1", "busy_o",       busy_o,       1'b0);
    check("R1", "frame_done_o", frame_done_o, 1'b0);
    check("R1", "parity_err_o", parity_err_o, 1'b0);
    rst_n = 1'b1;

    // R2 R3 R4 R5: exhaustive sweep of all frames, idle gaps vary per frame
    for (int f = 0; f < 256; f++) begin
      logic odd;
      odd = ($countones(f[7:0]) % 2) == 1;
      for (int i = 0; i < 8; i++) begin
        if (((f + i) % 3) == 0)
          cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, i != 0, "R3 idle");
        cyc(1'b1, f[i], 1'b0, 1'b1, i == 7, (i == 7) && odd, i != 0,
            (i == 7) ? "R5 verdict" : "R2 bit");
      end
      // R6 parked: offered bits are refused
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 parked");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 parked");
      // R8 re-arm pulse with a bit offered
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 sync");
    end

    // R7: mid-frame re-arm discards partial frame (three ones consumed)
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 bit");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R2 bit");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R2 bit");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8 collision");
    // fresh frame 0x01: odd, must finish on its own eighth bit
    for (int i = 0; i < 8; i++)
      cyc(1'b1, i == 0, 1'b0, 1'b1, i == 7, i == 7, i != 0, "R7 restart");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 sync");
    // fresh frame 0x03: even, no error
    for (int i = 0; i < 8; i++)
      cyc(1'b1, i < 2, 1'b0, 1'b1, i == 7, 1'b0, i != 0, "R7 restart");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 sync");
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 ready after sync");

    finish_run();
  end
endmodule